// File: doc/BRIEF.md
# Double-Buffered Ten-Bit PWM Generator

The block produces one pulse-width-modulated output. Software can change its duty at any moment without a glitch. An 8-bit timer counts from zero up to a programmable period limit, which sets the period. A 2-bit fine counter advances on every input clock and supplies the two least significant bits of a 10-bit compare. This gives the duty four times finer steps than the timer alone.

The timer advances once per wrap of the fine counter, further divided by a prescaler of 1, 4 or 16. One period therefore lasts (P+1)·4·D clocks, where P is the period limit and D is the prescale factor.

The duty value is written as an 8-bit upper part and a 2-bit lower part. It only takes effect when it is copied into a hidden shadow register, and that copy happens solely at the start of a period. The output rises at the start of each period and falls when the count reaches the shadow duty. A duty of zero keeps the output low for the whole period. A duty beyond the period keeps it high for the whole period. A one-clock pulse marks the start of every period.

Top module: `pwm_gen`

## Requirements
- R1: While reset is high and on the first clock after it, `pwm_o` and `period_start_o` are 0.
- R2: While `en_i` is 0, `pwm_o` and `period_start_o` stay 0. On the first rising edge where `en_i` is sampled 1, a period begins: `period_start_o` is 1 for that clock, and `pwm_o` equals (duty ≠ 0).
- R3: Consecutive `period_start_o` pulses are (P+1)·4·D clocks apart. P is `period_i`, and D is 1, 4 or 16 for `presc_sel_i` = 0, 1, or 2/3.
- R4: With a latched duty U = {`duty_hi_i`,`duty_lo_i`} that is nonzero and has U[9:2] ≤ P, `pwm_o` is high for U[9:2]·4·D + U[1:0] clocks from the period start and low for the rest of the period. With D = 1, each step of `duty_lo_i` changes the high time by one clock.
- R5: A latched duty of 0 keeps `pwm_o` low for the whole period.
- R6: A latched duty with U[9:2] > P keeps `pwm_o` high for the whole period.
- R7: A duty written during a period does not change that period's output. It is used from the next period start onwards.
- R8: `period_start_o` is a single-clock pulse, and `pwm_o` only rises on a clock where `period_start_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; 0 holds the block idle and low |
| period_i | input | 8 | Period limit P for the timer |
| presc_sel_i | input | 2 | Timer prescale: 0 gives /1, 1 gives /4, 2 or 3 give /16 |
| duty_hi_i | input | 8 | Pending duty, upper 8 bits |
| duty_lo_i | input | 2 | Pending duty, lower 2 bits |
| pwm_o | output | 1 | PWM output, registered |
| period_start_o | output | 1 | One-clock pulse at each period start, registered |

## Verification
The duty is tried at zero, at small values that only reach into the fine count, at exactly the period boundary, and above the period. These cases separate the zero-duty, fine-resolution, full-period and clear paths. Each prescale setting is run, so that an error in the division factor shows up in both the period length and the high time. A duty rewrite in mid-period tells a double-buffered shadow apart from a live compare. Random configurations then cover a mix of period and duty values and compare every measured high time and period length against the formulas.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PS_W = 4;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'd0,
    PS_DIV4   = 2'd1,
    PS_DIV16  = 2'd2,
    PS_DIV16B = 2'd3
  } presc_e;

  // Terminal value of the prescale counter for each setting
  function automatic logic [PS_W-1:0] ps_limit(input logic [1:0] sel);
    case (presc_e'(sel))
      PS_DIV1: ps_limit = '0;
      PS_DIV4: ps_limit = PS_W'(3);
      default: ps_limit = '1;
    endcase
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [TMR_W-1:0]  period_i,
  input  logic [1:0]        presc_sel_i,
  output logic              start_o,
  output logic [TMR_W-1:0]  tmr_nxt_o,
  output logic [FINE_W-1:0] fine_nxt_o
);
  logic              run_q;
  logic [FINE_W-1:0] fine_q;
  logic [PS_W-1:0]   ps_q, ps_nxt;
  logic [TMR_W-1:0]  tmr_q;
  logic              fine_wrap, ps_last, tick, wrap;

  assign fine_wrap = (fine_q == '1);
  assign ps_last   = (ps_q >= ps_limit(presc_sel_i));
  assign tick      = run_q && fine_wrap && ps_last;
  assign wrap      = tick && (tmr_q == period_i);
  assign start_o   = en && (!run_q || wrap);

  always_comb begin
    fine_nxt_o = '0;
    ps_nxt     = '0;
    tmr_nxt_o  = '0;
    if (en && run_q) begin
      fine_nxt_o = fine_q + 1'b1;
      ps_nxt     = fine_wrap ? (ps_last ? '0 : ps_q + 1'b1) : ps_q;
      tmr_nxt_o  = tick ? (wrap ? '0 : tmr_q + 1'b1) : tmr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      fine_q <= '0;
      ps_q   <= '0;
      tmr_q  <= '0;
    end else begin
      run_q  <= en;
      fine_q <= fine_nxt_o;
      ps_q   <= ps_nxt;
      tmr_q  <= tmr_nxt_o;
    end
  end

  // The timer moves only on a prescaled tick while running
  assert_timer_step_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(run_q) && run_q && !$past(tick)) |-> $stable(tmr_q));
endmodule

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DUTY_W-1:0] pend_i,
  output logic [DUTY_W-1:0] shadow_o
);
  always_ff @(posedge clk) begin
    if (rst)          shadow_o <= '0;
    else if (start_i) shadow_o <= pend_i;
  end

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(start_i) |-> $stable(shadow_o));
endmodule

// File: rtl/pwm_out.sv
module pwm_out #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start_i,
  input  logic [DUTY_W-1:0] pend_i,
  input  logic [DUTY_W-1:0] shadow_i,
  input  logic [DUTY_W-1:0] cnt_nxt_i,
  output logic              pin_o,
  output logic              mark_o
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pin_o  <= 1'b0;
      mark_o <= 1'b0;
    end else begin
      mark_o <= start_i;
      if (start_i) pin_o <= (pend_i != '0);
      else         pin_o <= pin_o && (cnt_nxt_i != shadow_i);
    end
  end

  assert_pin_low_off_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!pin_o && !mark_o));
  assert_match_single_R8: assert property (@(posedge clk) disable iff (rst)
    mark_o |=> !mark_o);
  assert_rise_at_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_o) |-> mark_o);
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen #(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [TMR_W-1:0]  period_i,
  input  logic [1:0]        presc_sel_i,
  input  logic [TMR_W-1:0]  duty_hi_i,
  input  logic [FINE_W-1:0] duty_lo_i,
  output logic              pwm_o,
  output logic              period_start_o
);
  localparam int DUTY_W = TMR_W + FINE_W;

  logic              start;
  logic [TMR_W-1:0]  tmr_nxt;
  logic [FINE_W-1:0] fine_nxt;
  logic [DUTY_W-1:0] pend, shadow;

  assign pend = {duty_hi_i, duty_lo_i};

  pwm_timebase #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_tb (
    .clk(clk), .rst(rst), .en(en_i), .period_i(period_i),
    .presc_sel_i(presc_sel_i), .start_o(start),
    .tmr_nxt_o(tmr_nxt), .fine_nxt_o(fine_nxt)
  );

  pwm_duty_buf #(.DUTY_W(DUTY_W)) u_buf (
    .clk(clk), .rst(rst), .start_i(start), .pend_i(pend), .shadow_o(shadow)
  );

  pwm_out #(.DUTY_W(DUTY_W)) u_out (
    .clk(clk), .rst(rst), .en(en_i), .start_i(start), .pend_i(pend),
    .shadow_i(shadow), .cnt_nxt_i({tmr_nxt, fine_nxt}),
    .pin_o(pwm_o), .mark_o(period_start_o)
  );

  assert_zero_duty_R5: assert property (@(posedge clk) disable iff (rst)
    (period_start_o && shadow == '0) |-> !pwm_o);
endmodule

// File: tb/tb_pwm_gen.sv
module tb_pwm_gen;
  logic       clk = 1'b0;
  logic       rst;
  logic       en_i;
  logic [7:0] period_i;
  logic [1:0] presc_sel_i;
  logic [7:0] duty_hi_i;
  logic [1:0] duty_lo_i;
  logic       pwm_o, period_start_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc++;

  pwm_gen dut (
    .clk(clk), .rst(rst), .en_i(en_i), .period_i(period_i),
    .presc_sel_i(presc_sel_i), .duty_hi_i(duty_hi_i), .duty_lo_i(duty_lo_i),
    .pwm_o(pwm_o), .period_start_o(period_start_o)
  );

  function automatic int div_of(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : 16;
  endfunction

  function automatic int exp_len(input int p, input logic [1:0] s);
    return (p + 1) * 4 * div_of(s);
  endfunction

  function automatic int exp_high(input int p, input logic [1:0] s, input logic [9:0] u);
    if (u == 10'd0) return 0;
    if (int'(u[9:2]) > p) return exp_len(p, s);
    return int'(u[9:2]) * 4 * div_of(s) + int'(u[1:0]);
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Restart: disable for one clock, load config, enable; returns at first start
  task automatic config_run(input logic [7:0] p, input logic [1:0] s, input logic [9:0] u);
    @(negedge clk);
    en_i = 1'b0;
    period_i = p; presc_sel_i = s; {duty_hi_i, duty_lo_i} = u;
    @(negedge clk);
    en_i = 1'b1;
    @(negedge clk);
  endtask

  // Entered on a negedge where period_start_o is 1; measures one period
  task automatic measure(input int chg_at, input logic [9:0] nd, output int hi, output int len);
    hi = 0; len = 0;
    do begin
      if (pwm_o) hi++;
      len++;
      if (len == chg_at) {duty_hi_i, duty_lo_i} = nd;
      @(negedge clk);
    end while (!period_start_o && len < 20000);
  endtask

  task automatic run_case(input string req, input logic [7:0] p, input logic [1:0] s, input logic [9:0] u);
    int hi, len;
    config_run(p, s, u);
    chk({req, " start pulse"}, int'(period_start_o), 1);
    measure(-1, u, hi, len);
    chk({req, " R3 length"}, len, exp_len(int'(p), s));
    chk({req, " high time"}, hi, exp_high(int'(p), s, u));
  endtask

  initial begin
    wait (done == 0);
    while (cyc < 190000 && !done) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int hi, len;
    rst = 1'b1; en_i = 1'b0; period_i = 8'd3; presc_sel_i = 2'd0;
    duty_hi_i = 8'd1; duty_lo_i = 2'd1;
    repeat (3) @(negedge clk);
    chk("R1 pwm in reset", int'(pwm_o), 0);
    chk("R1 start in reset", int'(period_start_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pwm after reset", int'(pwm_o), 0);
    repeat (5) @(negedge clk);
    chk("R2 pwm while off", int'(pwm_o), 0);
    chk("R2 no start while off", int'(period_start_o), 0);

    // First enable: period begins at once
    en_i = 1'b1;
    @(negedge clk);
    chk("R2 start on enable", int'(period_start_o), 1);
    chk("R2 pin on enable", int'(pwm_o), 1);
    measure(-1, 10'd0, hi, len);
    chk("R3 first length", len, exp_len(3, 2'd0));
    chk("R4 first high", hi, exp_high(3, 2'd0, 10'd5));
    // Disable mid-run: pin drops
    repeat (3) @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    chk("R2 pin drops when off", int'(pwm_o), 0);

    // Directed corner cases
    run_case("R4 fine only", 8'd5, 2'd0, 10'd3);
    run_case("R4 fine step", 8'd5, 2'd0, 10'd2);
    run_case("R4 at period", 8'd5, 2'd0, {8'd5, 2'd3});
    run_case("R5 zero duty", 8'd5, 2'd0, 10'd0);
    run_case("R5 zero duty div4", 8'd2, 2'd1, 10'd0);
    run_case("R6 over period", 8'd5, 2'd0, {8'd6, 2'd0});
    run_case("R6 max duty", 8'd4, 2'd1, 10'h3FF);
    run_case("R3 div4", 8'd7, 2'd1, {8'd3, 2'd1});
    run_case("R3 div16", 8'd3, 2'd2, {8'd2, 2'd2});
    run_case("R3 div16 alt", 8'd1, 2'd3, {8'd1, 2'd1});
    run_case("R4 period zero", 8'd0, 2'd0, 10'd2);

    // R7: rewrite mid-period, current period keeps old duty
    config_run(8'd9, 2'd0, {8'd2, 2'd0});
    measure(5, {8'd7, 2'd2}, hi, len);
    chk("R7 old duty kept", hi, exp_high(9, 2'd0, {8'd2, 2'd0}));
    measure(-1, 10'd0, hi, len);
    chk("R7 new duty next period", hi, exp_high(9, 2'd0, {8'd7, 2'd2}));
    chk("R8 one pulse per period", len, exp_len(9, 2'd0));

    // Constrained random configurations with a fixed seed
    void'($urandom(32'd1234));
    for (int i = 0; i < 20; i++) begin
      logic [7:0] p;
      logic [1:0] s;
      logic [9:0] u;
      p = 8'($urandom_range(0, 40));
      s = 2'($urandom_range(0, 2));
      u = 10'($urandom_range(0, 4 * (int'(p) + 2)));
      run_case("R4 random", p, s, u);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule